// File: doc/BRIEF.md
# Filtered Wake Input Detector

The block watches a set of digital wake inputs while the device sits in a permanent-sense mode. Each input has its own two-bit condition: disabled, high level, low level or change of state. Before a wake event is declared, an input has to meet its condition without a break for a filter time of a fixed number of 1 µs ticks. Each event sets a sticky flag for that input. An active-low interrupt stays asserted for as long as any flag is set.

A single write strobe loads the conditions of all inputs at once. In change-of-state mode, the level on the pin at the moment of that write becomes the first no-wake reference. After each event the reference follows the pin to its new level. When the switches are powered from a switched supply rail, detection is held off while that rail is down. A read strobe clears all flags. The pin comparators, the analog thresholds and the serial transport lie outside this block. The inputs are expected to be already synchronous to `clk`.

Top module: `wake_detect`

## Requirements
- R1: After reset every flag is 0, `irq_n` is 1 and every input is in the disabled condition.
- R2: Condition code 00 (disabled) never produces an event, whatever the pin does.
- R3: Code 01 qualifies while the pin is 1. Code 10 qualifies while the pin is 0.
- R4: An event fires on the `FILT_TICKS`-th (default 20) tick during which the input qualifies. The count restarts to zero in any cycle where the input does not qualify, where detection is gated, or where a configuration write occurs. A configuration write cycle produces no event.
- R5: Code 11 qualifies while the pin differs from a stored reference. The reference is loaded from the pin in the configuration write cycle and is replaced by the new pin level when an event fires.
- R6: While `sw_from_rail` is 1 and `rail_on` is 0, no input can reach an event. With `sw_from_rail` at 0, `rail_on` has no effect.
- R7: An event sets `stat_flags[i]` for input i. The flag stays set until a `stat_rd` strobe clears all flags. An event in the same cycle as `stat_rd` leaves its flag set.
- R8: `irq_n` is 0 exactly while at least one flag is set.
- R9: On `cfg_wr`, input i takes its condition code from `cfg_wdata[2i+1:2i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond; advances the filters |
| wake_in | input | NUM_IN | Wake pin levels, synchronous to clk |
| sw_from_rail | input | 1 | 1 when the switches are powered from the switched rail |
| rail_on | input | 1 | 1 while the switched rail is powered |
| cfg_wr | input | 1 | Write strobe for the condition codes |
| cfg_wdata | input | 2*NUM_IN | Two-bit condition code per input |
| stat_rd | input | 1 | Read strobe; clears all flags |
| stat_flags | output | NUM_IN | Sticky per-input wake flags |
| irq_n | output | 1 | Active-low wake interrupt |

## Verification
A flag appears one clock edge after the qualifying tick that completes the filter count. `irq_n` follows in the same cycle, because it is decoded from the flag registers. A write or a clear strobe acts at the edge on which it is sampled. The bench drives every strobe and tick for exactly one cycle between falling edges and samples on the next falling edge, so each result is read in the first cycle it is due. Each filter check reads the flags after the 19th tick and again after the 20th, which pins the event to one exact tick.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        WK_OFF    = 2'b00,
        WK_HIGH   = 2'b01,
        WK_LOW    = 2'b10,
        WK_TOGGLE = 2'b11
    } wk_mode_e;

    typedef struct packed {
        wk_mode_e mode;
        logic     ref_lvl;
    } wk_cfg_t;

    localparam wk_cfg_t WK_CFG_RESET = '{mode: WK_OFF, ref_lvl: 1'b0};

    // Does the pin level meet the programmed condition?
    function automatic logic wk_qualifies(input wk_cfg_t c, input logic lvl);
        logic q;
        case (c.mode)
            WK_HIGH:   q = lvl;
            WK_LOW:    q = ~lvl;
            WK_TOGGLE: q = (lvl != c.ref_lvl);
            default:   q = 1'b0;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/wake_cond.sv
module wake_cond
    import wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic       pin,
    input  logic       ev,
    output logic       qual
);
    wk_cfg_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= WK_CFG_RESET;
        end else if (cfg_wr) begin
            st_q.mode    <= wk_mode_e'(cfg_mode);
            st_q.ref_lvl <= pin;              // first reference for toggle mode
        end else if (ev && (st_q.mode == WK_TOGGLE)) begin
            st_q.ref_lvl <= pin;              // follow the new level
        end
    end

    assign qual = wk_qualifies(st_q, pin);

endmodule

// File: rtl/wake_filter.sv
module wake_filter #(
    parameter int FILT_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic qual,
    input  logic armed,
    input  logic restart,
    output logic ev
);
    localparam int            CNT_W = (FILT_TICKS > 2) ? $clog2(FILT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             hold;

    assign hold = qual && armed && !restart;
    assign ev   = hold && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !hold) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wake_status.sv
module wake_status #(
    parameter int NUM_IN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] ev,
    input  logic              clr,
    output logic [NUM_IN-1:0] flags,
    output logic              irq_n
);
    logic [NUM_IN-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (clr ? '0 : flags_q) | ev;
        end
    end

    assign flags = flags_q;
    assign irq_n = ~(|flags_q);

endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int NUM_IN     = 4,
    parameter int FILT_TICKS = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_1us,
    input  logic [NUM_IN-1:0]     wake_in,
    input  logic                  sw_from_rail,
    input  logic                  rail_on,
    input  logic                  cfg_wr,
    input  logic [2*NUM_IN-1:0]   cfg_wdata,
    input  logic                  stat_rd,
    output logic [NUM_IN-1:0]     stat_flags,
    output logic                  irq_n
);
    logic              armed;
    logic [NUM_IN-1:0] qual;
    logic [NUM_IN-1:0] ev;

    // Detection is held off while the switch supply rail is down
    assign armed = !(sw_from_rail && !rail_on);

    for (genvar g = 0; g < NUM_IN; g++) begin : g_chan
        wake_cond u_cond (
            .clk      (clk),
            .rst      (rst),
            .cfg_wr   (cfg_wr),
            .cfg_mode (cfg_wdata[2*g +: 2]),
            .pin      (wake_in[g]),
            .ev       (ev[g]),
            .qual     (qual[g])
        );

        wake_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick_1us),
            .qual    (qual[g]),
            .armed   (armed),
            .restart (cfg_wr),
            .ev      (ev[g])
        );
    end

    wake_status #(.NUM_IN(NUM_IN)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .clr   (stat_rd),
        .flags (stat_flags),
        .irq_n (irq_n)
    );

endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk #(
    parameter int NUM_IN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_1us,
    input logic              sw_from_rail,
    input logic              rail_on,
    input logic              cfg_wr,
    input logic              stat_rd,
    input logic [NUM_IN-1:0] stat_flags,
    input logic              irq_n
);
    // R7: without a clear, no flag falls
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> (($past(stat_flags) & ~stat_flags) == '0));

    // R7: a clear with no tick leaves all flags low
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !tick_1us) |=> (stat_flags == '0));

    // R8: the interrupt is released after such a clear
    p_irq_release_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !tick_1us) |=> irq_n);

    // R4: no flag rises without a tick or in a write cycle
    p_tick_only_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick_1us || cfg_wr) |=> ((stat_flags & ~$past(stat_flags)) == '0));

    // R6: no flag rises while the rail gate holds detection off
    p_rail_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_from_rail && !rail_on) |=> ((stat_flags & ~$past(stat_flags)) == '0));

endmodule

bind wake_detect wake_detect_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_1us     (tick_1us),
    .sw_from_rail (sw_from_rail),
    .rail_on      (rail_on),
    .cfg_wr       (cfg_wr),
    .stat_rd      (stat_rd),
    .stat_flags   (stat_flags),
    .irq_n        (irq_n)
);

// File: tb/wake_detect_tb.sv
module wake_detect_tb;
    localparam int N    = 4;
    localparam int FILT = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick_1us = 1'b0;
    logic [N-1:0]   wake_in = '0;
    logic           sw_from_rail = 1'b0;
    logic           rail_on = 1'b0;
    logic           cfg_wr = 1'b0;
    logic [2*N-1:0] cfg_wdata = '0;
    logic           stat_rd = 1'b0;
    logic [N-1:0]   stat_flags;
    logic           irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wake_detect #(.NUM_IN(N), .FILT_TICKS(FILT)) u_dut (
        .clk(clk), .rst(rst), .tick_1us(tick_1us), .wake_in(wake_in),
        .sw_from_rail(sw_from_rail), .rail_on(rail_on), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .stat_flags(stat_flags),
        .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick_1us = 1'b1;
            @(negedge clk) tick_1us = 1'b0;
        end
    endtask

    task automatic write_cfg(input logic [2*N-1:0] d);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_wdata = d; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic read_clr();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    // Expected qualification from the requirement text
    function automatic logic exp_q(input int m, input logic ref_lvl, input logic lvl);
        case (m)
            1: return lvl;
            2: return ~lvl;
            3: return lvl != ref_lvl;
            default: return 1'b0;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state; all inputs disabled, so high pins do nothing
        chk("R1 flags", stat_flags, 0);
        chk("R1 irq_n", irq_n, 1);
        wake_in = '1;
        ticks(FILT + 2);
        chk("R1 disabled after reset", stat_flags, 0);

        // Sweep: input i gets code (m+i)%4, pins preset p, then level v
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int v = 0; v < 2; v++) begin
                    logic [2*N-1:0] d;
                    logic [N-1:0]   e;
                    for (int i = 0; i < N; i++) begin
                        d[2*i +: 2] = 2'((m + i) % 4);
                        e[i] = exp_q((m + i) % 4, p[0], v[0]);
                    end
                    read_clr();
                    @(negedge clk) wake_in = {N{p[0]}};
                    write_cfg(d);
                    @(negedge clk) wake_in = {N{v[0]}};
                    ticks(FILT - 1);
                    chk("R4 R2 no event before filter", stat_flags, 0);
                    ticks(1);
                    chk("R2 R3 R5 R9 sweep flags", stat_flags, e);
                    chk("R8 irq_n follows flags", irq_n, (e == '0));
                end
            end
        end

        // R7: read strobe clears all flags
        read_clr();
        chk("R7 clear", stat_flags, 0);
        chk("R8 irq released", irq_n, 1);

        // R4: a one-cycle drop restarts the count
        @(negedge clk) wake_in = '0;
        write_cfg(8'b00_00_00_01);
        @(negedge clk) wake_in = 4'b0001;
        ticks(15);
        @(negedge clk) wake_in = 4'b0000;
        @(negedge clk) wake_in = 4'b0001;
        ticks(FILT - 1);
        chk("R4 restart no event", stat_flags, 0);
        ticks(1);
        chk("R4 restart event", stat_flags, 4'b0001);

        // R7: event in the same cycle as a read survives
        read_clr();
        ticks(FILT - 1);
        @(negedge clk) begin tick_1us = 1'b1; stat_rd = 1'b1; end
        @(negedge clk) begin tick_1us = 1'b0; stat_rd = 1'b0; end
        chk("R7 event beats clear", stat_flags, 4'b0001);

        // R5: reference follows the pin after an event
        read_clr();
        @(negedge clk) wake_in = 4'b0000;
        write_cfg(8'b00_00_00_11);
        @(negedge clk) wake_in = 4'b0001;
        ticks(FILT);
        chk("R5 first toggle", stat_flags, 4'b0001);
        read_clr();
        ticks(2 * FILT);
        chk("R5 reference updated", stat_flags, 0);
        @(negedge clk) wake_in = 4'b0000;
        ticks(FILT);
        chk("R5 toggle back", stat_flags, 4'b0001);

        // R6: gating by the switched rail
        read_clr();
        @(negedge clk) begin sw_from_rail = 1'b1; rail_on = 1'b0; wake_in = 4'b0001; end
        write_cfg(8'b00_00_00_01);
        ticks(2 * FILT);
        chk("R6 rail off blocks", stat_flags, 0);
        @(negedge clk) rail_on = 1'b1;
        ticks(FILT - 1);
        chk("R6 rail on filter", stat_flags, 0);
        ticks(1);
        chk("R6 rail on event", stat_flags, 4'b0001);
        read_clr();
        @(negedge clk) begin sw_from_rail = 1'b0; rail_on = 1'b0; end
        ticks(FILT);
        chk("R6 rail ignored when not switched", stat_flags, 4'b0001);

        // R4: a config write restarts the filter
        read_clr();
        ticks(FILT - 1);
        write_cfg(8'b00_00_00_01);
        ticks(FILT - 1);
        chk("R4 write restarts", stat_flags, 0);
        ticks(1);
        chk("R4 after write", stat_flags, 4'b0001);

        finish_run();
    end
endmodule